// File: doc/BRIEF.md
# Flash Command Sequence Controller

This block is the command front end of a byte-wide parallel flash model. A host drives an address bus, a data byte and an active-low write strobe. Each low pulse of the strobe is one command cycle. The block captures the address when the strobe falls and the data when it rises. A sequencer matches these cycles against fixed unlock patterns. It recognises byte program, sector erase and chip erase, and it recognises entry to and exit from an identification read mode.

A recognised program or erase launches a self-timed internal operation on a behavioural byte array held inside the block. A down-counter times the operation in clock cycles. While the operation runs the block reports busy and holds the operation type and its latched address and data at its outputs. When the count expires the block updates the array, drops busy and returns to normal reads on its own. In identification mode, reads of the two lowest addresses return fixed identifier bytes in place of array data.

The block is configured through parameters: the address width, the sector size and the three operation lengths in cycles.

Top module: `flash_cmd_ctrl`

## Requirements
- R1: One command cycle is one low pulse of `we_n`. The address is taken in the clock cycle where `we_n` is seen to fall. The data byte is taken where `we_n` is seen to rise, and the address bus value at that moment is not used. The first unlock address KA is the alternating pattern 0x55 for an 8-bit address bus, and the second unlock address KB is its complement, 0xAA.
- R2: The cycles (KA,0xAA), (KB,0x55), (KA,0xA0), followed by any (address, data) cycle, start a byte program of that data at that address.
- R3: The cycles (KA,0xAA), (KB,0x55), (KA,0x80), (KA,0xAA), (KB,0x55), (SA,0x30) start a sector erase. The sector is address bits [AW-1:SW], taken from the falling-edge address of the sixth cycle. Only the bytes of that sector become 0xFF.
- R4: The same first five cycles followed by (KA,0x10) start a chip erase that sets every byte to 0xFF.
- R5: A program stores the old byte AND the data byte, so it can only clear bits.
- R6: Identification mode is entered by (KA,0xAA), (KB,0x55), (KA,0x90), or by the five erase prefix cycles followed by (KA,0x60). In this mode `rdata` is 0xDA at address 0, 0xB0 at address 1, and 0x00 at every other address. The array is not changed.
- R7: Identification mode is left by (KA,0xAA), (KB,0x55), (KA,0xF0), or by a single cycle with data 0xF0 at any address while the sequencer is idle. After exit, reads return array data again.
- R8: `busy` rises in the clock after the completing cycle and stays high for exactly PROG_CYC, SECT_CYC or CHIP_CYC cycles. The array changes in the same clock that `busy` falls. `op` is 1 for program, 2 for sector erase and 3 for chip erase. `op`, `op_addr` and `op_data` hold steady while the operation runs.
- R9: Command cycles that complete while `busy` is high are ignored. They do not change the array, the operation in progress or its end time.
- R10: A cycle that does not match the expected step sends the sequencer back to idle. That cycle is not reused as a first step, and the array is left unchanged.
- R11: After reset, `busy` is 0, `op` is 0, identification mode is off and every array byte reads 0xFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| we_n | input | 1 | Active-low write strobe; one low pulse is one command cycle |
| addr | input | AW | Address for command cycles and reads |
| wdata | input | 8 | Command or program data byte |
| rdata | output | 8 | Array byte or identifier byte at `addr` |
| busy | output | 1 | An internal operation is running |
| op | output | 2 | Operation type: 0 none, 1 program, 2 sector erase, 3 chip erase |
| op_addr | output | AW | Address latched for the running operation |
| op_data | output | 8 | Data latched for the running operation |

## Verification
The bench drives a different address on the rising strobe edge than on the falling one. A design that samples the address at the wrong edge programs the wrong byte or erases the wrong sector. It fills the whole array with an address-derived pattern and checks every byte after a sector erase, so an erase that spills into a neighbouring sector or misses part of its own is caught. Busy is sampled on the last cycle of each operation and on the cycle after, so an off-by-one in the timer is reported. The bench also sends full command sequences during busy, breaks sequences partway, writes a mismatched first step twice in a row, and uses both entry paths and both exit paths of identification mode. A design that restarts early, reuses a mismatched cycle or fails to leave identification mode shows wrong read data.

// File: rtl/flash_cmd_pkg.sv
`timescale 1ns/1ps
package flash_cmd_pkg;
  typedef enum logic [1:0] {
    OP_NONE = 2'd0,
    OP_PROG = 2'd1,
    OP_SECT = 2'd2,
    OP_CHIP = 2'd3
  } op_e;

  localparam logic [7:0] KEY_LO   = 8'hAA;
  localparam logic [7:0] KEY_HI   = 8'h55;
  localparam logic [7:0] CMD_PROG = 8'hA0;
  localparam logic [7:0] CMD_ERS  = 8'h80;
  localparam logic [7:0] CMD_CHIP = 8'h10;
  localparam logic [7:0] CMD_SECT = 8'h30;
  localparam logic [7:0] CMD_ID3  = 8'h90;
  localparam logic [7:0] CMD_ID6  = 8'h60;
  localparam logic [7:0] CMD_EXIT = 8'hF0;
  localparam logic [7:0] ID_MFR   = 8'hDA;
  localparam logic [7:0] ID_DEV   = 8'hB0;

  // Programming can only pull bits low.
  function automatic logic [7:0] prog_merge(input logic [7:0] old_v, input logic [7:0] new_v);
    return old_v & new_v;
  endfunction

  function automatic logic [7:0] id_byte(input logic is_zero, input logic is_one);
    if (is_zero) return ID_MFR;
    if (is_one)  return ID_DEV;
    return 8'h00;
  endfunction
endpackage

// File: rtl/fcc_we_capture.sv
`timescale 1ns/1ps
module fcc_we_capture #(
  parameter int AW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we_n,
  input  logic [AW-1:0] addr,
  input  logic [7:0]    wdata,
  output logic          cyc_stb,
  output logic [AW-1:0] cyc_addr,
  output logic [7:0]    cyc_data
);
  logic          we_q;
  logic [AW-1:0] addr_lat;
  logic          fall_seen;

  assign fall_seen = we_q & ~we_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      we_q     <= 1'b1;
      addr_lat <= '0;
    end else begin
      we_q <= we_n;
      if (fall_seen) addr_lat <= addr;
    end
  end

  assign cyc_stb  = ~we_q & we_n;
  assign cyc_addr = addr_lat;
  assign cyc_data = wdata;
endmodule

// File: rtl/fcc_cmd_seq.sv
`timescale 1ns/1ps
module fcc_cmd_seq
  import flash_cmd_pkg::*;
#(
  parameter int AW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          stb,
  input  logic [AW-1:0] c_addr,
  input  logic [7:0]    c_data,
  output logic          start,
  output op_e           start_op,
  output logic          id_mode
);
  localparam logic [AW-1:0] KA = {(AW/2){2'b01}};
  localparam logic [AW-1:0] KB = ~KA;

  typedef enum logic [2:0] {S_IDLE, S_U1, S_U2, S_PROG, S_E3, S_E4, S_E5} seq_e;
  seq_e st, nxt;
  logic hit1, hit2, at_ka, id_set, id_clr;

  assign at_ka = (c_addr == KA);
  assign hit1  = at_ka && (c_data == KEY_LO);
  assign hit2  = (c_addr == KB) && (c_data == KEY_HI);

  always_comb begin
    nxt = st; start = 1'b0; start_op = OP_NONE; id_set = 1'b0; id_clr = 1'b0;
    if (stb) begin
      unique case (st)
        S_IDLE: if (hit1) nxt = S_U1; else if (c_data == CMD_EXIT) id_clr = 1'b1;
        S_U1:   nxt = hit2 ? S_U2 : S_IDLE;
        S_U2: begin
          nxt = S_IDLE;
          if (at_ka) begin
            case (c_data)
              CMD_PROG: nxt = S_PROG;
              CMD_ERS:  nxt = S_E3;
              CMD_ID3:  id_set = 1'b1;
              CMD_EXIT: id_clr = 1'b1;
              default:  ;
            endcase
          end
        end
        S_PROG: begin nxt = S_IDLE; start = 1'b1; start_op = OP_PROG; end
        S_E3:   nxt = hit1 ? S_E4 : S_IDLE;
        S_E4:   nxt = hit2 ? S_E5 : S_IDLE;
        S_E5: begin
          nxt = S_IDLE;
          if (at_ka && c_data == CMD_CHIP) begin start = 1'b1; start_op = OP_CHIP; end
          else if (c_data == CMD_SECT)     begin start = 1'b1; start_op = OP_SECT; end
          else if (at_ka && c_data == CMD_ID6) id_set = 1'b1;
        end
        default: nxt = S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= S_IDLE;
      id_mode <= 1'b0;
    end else begin
      st <= nxt;
      if (id_set)      id_mode <= 1'b1;
      else if (id_clr) id_mode <= 1'b0;
    end
  end
endmodule

// File: rtl/fcc_op_timer.sv
`timescale 1ns/1ps
module fcc_op_timer
  import flash_cmd_pkg::*;
#(
  parameter int AW       = 8,
  parameter int PROG_CYC = 100,
  parameter int SECT_CYC = 1500,
  parameter int CHIP_CYC = 1000
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  op_e           start_op,
  input  logic [AW-1:0] start_addr,
  input  logic [7:0]    start_data,
  output logic          busy,
  output op_e           op,
  output logic [AW-1:0] op_addr,
  output logic [7:0]    op_data,
  output logic          done
);
  localparam int MAXC = (PROG_CYC > SECT_CYC) ?
                        ((PROG_CYC > CHIP_CYC) ? PROG_CYC : CHIP_CYC) :
                        ((SECT_CYC > CHIP_CYC) ? SECT_CYC : CHIP_CYC);
  localparam int CW = $clog2(MAXC + 1);

  logic [CW-1:0] cnt;

  function automatic logic [CW-1:0] last_tick(input op_e o);
    case (o)
      OP_PROG: return CW'(PROG_CYC - 1);
      OP_SECT: return CW'(SECT_CYC - 1);
      default: return CW'(CHIP_CYC - 1);
    endcase
  endfunction

  assign done = busy && (cnt == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0; op <= OP_NONE; op_addr <= '0; op_data <= '0; cnt <= '0;
    end else if (done) begin
      busy <= 1'b0; op <= OP_NONE;
    end else if (busy) begin
      cnt <= cnt - 1'b1;
    end else if (start) begin
      busy <= 1'b1; op <= start_op; op_addr <= start_addr; op_data <= start_data;
      cnt <= last_tick(start_op);
    end
  end
endmodule

// File: rtl/fcc_mem_array.sv
`timescale 1ns/1ps
module fcc_mem_array
  import flash_cmd_pkg::*;
#(
  parameter int AW = 8,
  parameter int SW = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          done,
  input  op_e           op,
  input  logic [AW-1:0] op_addr,
  input  logic [7:0]    op_data,
  input  logic [AW-1:0] rd_addr,
  output logic [7:0]    rd_val
);
  localparam int DEPTH = 1 << AW;

  logic [7:0] mem [DEPTH];

  function automatic logic same_sector(input logic [AW-1:0] a, input logic [AW-1:0] b);
    return a[AW-1:SW] == b[AW-1:SW];
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= 8'hFF;
    end else if (done) begin
      for (int i = 0; i < DEPTH; i++) begin
        case (op)
          OP_PROG: if (op_addr == AW'(i)) mem[i] <= prog_merge(mem[i], op_data);
          OP_SECT: if (same_sector(op_addr, AW'(i))) mem[i] <= 8'hFF;
          OP_CHIP: mem[i] <= 8'hFF;
          default: ;
        endcase
      end
    end
  end

  assign rd_val = mem[rd_addr];
endmodule

// File: rtl/flash_cmd_ctrl.sv
`timescale 1ns/1ps
module flash_cmd_ctrl
  import flash_cmd_pkg::*;
#(
  parameter int AW       = 8,
  parameter int SW       = 5,
  parameter int PROG_CYC = 100,
  parameter int SECT_CYC = 1500,
  parameter int CHIP_CYC = 1000
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we_n,
  input  logic [AW-1:0] addr,
  input  logic [7:0]    wdata,
  output logic [7:0]    rdata,
  output logic          busy,
  output logic [1:0]    op,
  output logic [AW-1:0] op_addr,
  output logic [7:0]    op_data
);
  logic          cyc_stb, accept, start, id_mode, done;
  logic [AW-1:0] cyc_addr;
  logic [7:0]    cyc_data, arr_rd;
  op_e           start_op, op_i;

  fcc_we_capture #(.AW(AW)) u_cap (
    .clk(clk), .rst_n(rst_n), .we_n(we_n), .addr(addr), .wdata(wdata),
    .cyc_stb(cyc_stb), .cyc_addr(cyc_addr), .cyc_data(cyc_data));

  assign accept = cyc_stb & ~busy;

  fcc_cmd_seq #(.AW(AW)) u_seq (
    .clk(clk), .rst_n(rst_n), .stb(accept), .c_addr(cyc_addr), .c_data(cyc_data),
    .start(start), .start_op(start_op), .id_mode(id_mode));

  fcc_op_timer #(.AW(AW), .PROG_CYC(PROG_CYC), .SECT_CYC(SECT_CYC), .CHIP_CYC(CHIP_CYC)) u_tmr (
    .clk(clk), .rst_n(rst_n), .start(start), .start_op(start_op),
    .start_addr(cyc_addr), .start_data(cyc_data),
    .busy(busy), .op(op_i), .op_addr(op_addr), .op_data(op_data), .done(done));

  fcc_mem_array #(.AW(AW), .SW(SW)) u_mem (
    .clk(clk), .rst_n(rst_n), .done(done), .op(op_i), .op_addr(op_addr),
    .op_data(op_data), .rd_addr(addr), .rd_val(arr_rd));

  assign op    = op_i;
  assign rdata = id_mode ? id_byte(addr == '0, addr == AW'(1)) : arr_rd;
endmodule

// File: rtl/flash_cmd_ctrl_chk.sv
`timescale 1ns/1ps
module flash_cmd_ctrl_chk #(
  parameter int AW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          busy,
  input logic [1:0]    op,
  input logic [AW-1:0] op_addr,
  input logic [7:0]    op_data,
  input logic          start,
  input logic          done,
  input logic          cyc_stb,
  input logic          id_mode,
  input logic [AW-1:0] addr,
  input logic [7:0]    rdata
);
  assert_start_busy_R8: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> busy && (op != 2'd0));
  assert_done_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !busy && (op == 2'd0));
  assert_op_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !done) |=> $stable(op) && $stable(op_addr) && $stable(op_data));
  assert_ignore_busy_R9: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !start);
  assert_start_needs_cycle_R10: assert property (@(posedge clk) disable iff (!rst_n)
    start |-> cyc_stb);
  assert_id_mfr_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (id_mode && addr == '0) |-> rdata == 8'hDA);
  assert_id_dev_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (id_mode && addr == AW'(1)) |-> rdata == 8'hB0);
  assert_idle_op_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> op == 2'd0);
endmodule

bind flash_cmd_ctrl flash_cmd_ctrl_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .op(op), .op_addr(op_addr), .op_data(op_data),
  .start(start), .done(done), .cyc_stb(cyc_stb), .id_mode(id_mode),
  .addr(addr), .rdata(rdata));

// File: tb/tb_flash_cmd_ctrl.sv
`timescale 1ns/1ps
module tb_flash_cmd_ctrl;
  localparam int AW = 8, SW = 5, PC = 20, SC = 60, CC = 40;
  localparam logic [7:0] KA = 8'h55, KB = 8'hAA;

  logic clk = 0, rst_n = 0, we_n = 1;
  logic [AW-1:0] addr = '0, op_addr;
  logic [7:0] wdata = '0, rdata, op_data;
  logic busy;
  logic [1:0] op;
  int checks = 0, errors = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  flash_cmd_ctrl #(.AW(AW), .SW(SW), .PROG_CYC(PC), .SECT_CYC(SC), .CHIP_CYC(CC)) dut (
    .clk(clk), .rst_n(rst_n), .we_n(we_n), .addr(addr), .wdata(wdata),
    .rdata(rdata), .busy(busy), .op(op), .op_addr(op_addr), .op_data(op_data));

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Address on the falling strobe edge, a different address while it rises (R1).
  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk); addr = a; wdata = ~d; we_n = 0;
    @(negedge clk); addr = ~a; wdata = d; we_n = 1;
    @(negedge clk);
  endtask

  task automatic rd(input logic [7:0] a, output logic [7:0] v);
    @(negedge clk); addr = a; #1 v = rdata;
  endtask

  function automatic logic [7:0] pat(input int a);
    return 8'(a) ^ 8'h3C;
  endfunction

  task automatic unlock(); wr(KA, 8'hAA); wr(KB, 8'h55); endtask
  task automatic erase_prefix(); unlock(); wr(KA, 8'h80); unlock(); endtask

  task automatic wait_done(input int n, input string tag);
    repeat (n - 1) @(negedge clk);
    #1 chk({tag, " busy on last cycle"}, busy, 1);
    @(negedge clk); #1 chk({tag, " busy falls"}, busy, 0);
  endtask

  initial begin
    logic [7:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R11 reset state
    #1 chk("R11 busy", busy, 0); chk("R11 op", op, 0);
    for (int a = 0; a < 256; a += 37) begin rd(8'(a), v); chk("R11 erased", v, 8'hFF); end

    // R2/R8 program timing and latched fields
    unlock(); wr(KA, 8'hA0); wr(8'h10, 8'h5A);
    addr = 8'h10; #1;
    chk("R8 op prog", op, 1); chk("R1 op_addr", op_addr, 8'h10); chk("R8 op_data", op_data, 8'h5A);
    repeat (PC - 1) @(negedge clk);
    #1 chk("R8 busy last", busy, 1); chk("R8 array unchanged before end", rdata, 8'hFF);
    @(negedge clk); #1 chk("R8 busy falls", busy, 0); chk("R2 programmed", rdata, 8'h5A);

    // R5 bits only clear
    unlock(); wr(KA, 8'hA0); wr(8'h10, 8'hF0); wait_done(PC, "R5");
    rd(8'h10, v); chk("R5 and-merge", v, 8'h50);

    // R9 full sequence during busy is ignored
    unlock(); wr(KA, 8'hA0); wr(8'h20, 8'h00);
    unlock(); wr(KA, 8'hA0); wr(8'h21, 8'h00);   // 12 negedges used
    repeat (PC - 1 - 12) @(negedge clk);
    #1 chk("R9 end time unchanged", busy, 1);
    @(negedge clk); #1 chk("R9 busy falls on time", busy, 0);
    repeat (4) @(negedge clk); #1 chk("R9 no late start", busy, 0);
    rd(8'h20, v); chk("R9 first op done", v, 8'h00);
    rd(8'h21, v); chk("R9 ignored program", v, 8'hFF);

    // R10 mismatched step is not reused as a first step
    wr(KA, 8'hAA); wr(KA, 8'hAA); wr(KB, 8'h55); wr(KA, 8'hA0); wr(8'h30, 8'h00);
    #1 chk("R10 no start", busy, 0);
    rd(8'h30, v); chk("R10 array untouched", v, 8'hFF);
    unlock(); wr(KA, 8'h80); wr(KA, 8'hAA); wr(8'h11, 8'h55); wr(KA, 8'h10);
    #1 chk("R10 broken erase", busy, 0);
    rd(8'h10, v); chk("R10 data kept", v, 8'h50);

    // R4 chip erase
    erase_prefix(); wr(KA, 8'h10);
    #1 chk("R4 op chip", op, 3);
    wait_done(CC, "R4");
    for (int a = 0; a < 256; a++) begin rd(8'(a), v); chk("R4 all erased", v, 8'hFF); end

    // Exhaustive fill
    for (int a = 0; a < 256; a++) begin
      unlock(); wr(KA, 8'hA0); wr(8'(a), pat(a)); repeat (PC) @(negedge clk);
    end
    for (int a = 0; a < 256; a++) begin rd(8'(a), v); chk("R2 fill", v, pat(a)); end

    // R3 sector erase: fall address in sector 2, rise address elsewhere
    erase_prefix(); wr(8'h47, 8'h30);
    #1 chk("R3 op sect", op, 2); chk("R3 op_addr", op_addr, 8'h47);
    wait_done(SC, "R3");
    for (int a = 0; a < 256; a++) begin
      rd(8'(a), v);
      chk("R3 sector only", v, ((a >> SW) == 2) ? 8'hFF : pat(a));
    end

    // R6 three-cycle entry, R7 single-cycle exit
    unlock(); wr(KA, 8'h90);
    rd(8'h00, v); chk("R6 mfr", v, 8'hDA);
    rd(8'h01, v); chk("R6 dev", v, 8'hB0);
    rd(8'h02, v); chk("R6 other", v, 8'h00);
    wr(8'h33, 8'hF0);
    rd(8'h00, v); chk("R7 single exit", v, pat(0));
    // R6 six-cycle entry, R7 three-cycle exit
    erase_prefix(); wr(KA, 8'h60);
    #1 chk("R6 no erase", busy, 0);
    rd(8'h01, v); chk("R6 six-cycle dev", v, 8'hB0);
    unlock(); wr(KA, 8'hF0);
    rd(8'h01, v); chk("R7 three-cycle exit", v, pat(1));
    rd(8'h47, v); chk("R6 array intact", v, 8'hFF);

    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule